// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. Its byte-wide array holds up to 2 KB. The bus lines arrive as raw samples in the system clock domain. The block synchronises them and finds START, STOP and the SCL edges. It decodes a device-select byte and answers by enabling an open-drain pull-down on SDA. Behind the bus engine sit a 16-entry page buffer and the array itself.

A write loads an address pointer and then collects up to 16 data bytes in the page buffer. The bytes land in the array only when STOP arrives. That STOP opens a busy window, whose length is set by a parameter. Inside the window the device leaves its select byte unacknowledged, so a host can poll until an ACK comes back. Reads can start at the current pointer, or at an address set by a dummy write followed by a repeated START. They stream onward through the whole array. The density parameter decides how many of the three extension bits in the select byte are compared with strap pins and how many become high memory address bits.

Top module: `twi_eeprom_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. SCL pulses with no START before them get no acknowledge.
- R2: A select byte is accepted only if bits 7..4 equal 1010 and the strap bits it must match are equal. With the default 4 Kbit density, bits 3 and 2 are compared with strap bits 2 and 1. Bit 1 becomes memory address bit 8. Bit 0 is 1 for read and 0 for write.
- R3: The slave acknowledges by pulling SDA low during the 9th clock of an accepted select byte and of every byte it receives in a write. It changes its pull-down only while SCL is low.
- R4: In a write, the byte after the select byte loads the low 8 pointer bits. A following data byte is stored at that address once STOP arrives.
- R5: In a page write, only pointer bits 3..0 advance, and they wrap inside the 16-byte page. A byte sent more than 16 positions after the first one overwrites the earlier byte at the same offset.
- R6: Only offsets that received a byte are written at STOP. The other bytes of that page keep their values.
- R7: From a STOP that ends a write with data, and for WR_CYCLES clocks, no select byte is acknowledged. After that the select byte is acknowledged again.
- R8: A STOP that follows a write with no data byte starts no busy window. A select byte that comes right after it is acknowledged.
- R9: A read select byte with no address byte before it returns data from the current pointer, which is the location after the last byte read.
- R10: A dummy write of the address, then a repeated START with the read bit set, returns the data at that address.
- R11: A sequential read advances the pointer across the whole array and wraps from the last location to 0. The slave releases SDA in each 9th clock. It stops sending when the master does not acknowledge.
- R12: After reset every location reads FFh, and the pull-down is off.
- R13: If a START or STOP arrives in the middle of a byte, the partial byte is dropped. Complete bytes before a STOP are still written. A repeated START throws away any pending data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock sample |
| sda_i | input | 1 | Raw serial data sample (resolved line level) |
| strap_i | input | 3 | Device address strap pins |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The STOP that ends a write does two jobs in one clock: it drops any partial byte and it starts the commit with its busy window. The bench provokes this by stopping halfway through a second data byte. It then reads back the completed byte and the untouched neighbour. A second pair of events can also meet. One is the end of the busy window and the other is the ack decision for a polling select byte. The bench polls back to back from the moment STOP ends. It judges the outcome in three steps. The first poll, sent at once, must be refused. Some later poll must be accepted. The written byte must then read back intact.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

    localparam logic [3:0] DEV_CODE   = 4'b1010;
    localparam int         PAGE_BYTES = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WDATA,
        ST_RDATA
    } twi_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    // The top 3-ext extension bits are compared with the straps; the low ext bits carry the address.
    function automatic logic dev_match(input logic [7:0] dev, input logic [2:0] strap, input int ext);
        return (dev[7:4] == DEV_CODE) && ((dev[3:1] >> ext) == (strap >> ext));
    endfunction

endpackage

// File: rtl/twi_bus_sense.sv
module twi_bus_sense
    import twi_ee_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_m, scl_s, scl_q;
    logic sda_m, sda_s, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            {scl_m, scl_s, scl_q} <= 3'b111;
            {sda_m, sda_s, sda_q} <= 3'b111;
        end else begin
            scl_m <= scl_i;
            scl_s <= scl_m;
            scl_q <= scl_s;
            sda_m <= sda_i;
            sda_s <= sda_m;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.start, ev.stop, ev.rise, ev.fall})); // R1

endmodule

// File: rtl/twi_ee_array.sv
module twi_ee_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf
    import twi_ee_pkg::*;
#(
    parameter int AW        = 9,
    parameter int WR_CYCLES = 300,
    parameter int PW        = $clog2(PAGE_BYTES),
    parameter int CW        = $clog2(WR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [PW-1:0]    load_off,
    input  logic [7:0]       load_data,
    input  logic             go,
    input  logic [AW-PW-1:0] go_base,
    output logic             busy,
    output logic             pending,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [7:0]       mem_wdata
);
    logic [7:0]            slot [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic                  committing;
    logic [PW-1:0]         idx;
    logic [AW-PW-1:0]      base;
    logic [CW-1:0]         wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid      <= '0;
            committing <= 1'b0;
            idx        <= '0;
            base       <= '0;
            wait_cnt   <= '0;
        end else begin
            if (go) begin
                committing <= 1'b1;
                idx        <= '0;
                base       <= go_base;
                wait_cnt   <= CW'(WR_CYCLES);
            end else begin
                if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
                if (committing) begin
                    valid[idx] <= 1'b0;
                    idx        <= idx + 1'b1;
                    if (idx == PW'(PAGE_BYTES - 1)) committing <= 1'b0;
                end
            end
            if (clear && !busy) valid <= '0;
            if (load && !busy) begin
                valid[load_off] <= 1'b1;
                slot[load_off]  <= load_data;
            end
        end
    end

    assign busy      = committing || (wait_cnt != '0);
    assign pending   = |valid;
    assign mem_we    = committing && valid[idx];
    assign mem_waddr = {base, idx};
    assign mem_wdata = slot[idx];

    AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (rst)
        (load && !busy && !go) |=> valid[$past(load_off)]); // R5

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_ee_pkg::*;
#(
    parameter int DENSITY_KBIT = 4,
    parameter int WR_CYCLES    = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_pull_o
);
    localparam int DEPTH = DENSITY_KBIT * 128;
    localparam int AW    = $clog2(DEPTH);
    localparam int EXT   = AW - 8;
    localparam int EXTW  = (EXT > 0) ? EXT : 1;
    localparam int PW    = $clog2(PAGE_BYTES);

    bus_ev_t       ev;
    twi_state_e    st;
    logic [3:0]    bit_cnt;
    logic [7:0]    rx;
    logic [6:0]    tx;
    logic [AW-1:0] ptr;
    logic [EXTW-1:0] ext_q;
    logic          m_ack;
    logic          pull;

    logic          busy, pending, mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_wdata, rd_byte;
    logic [EXTW+7:0] full_ptr;
    logic          byte_end, ack_end, dev_ok, buf_load, commit_go;

    twi_bus_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    twi_page_buf #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_page (
        .clk       (clk),
        .rst       (rst),
        .clear     (ev.start),
        .load      (buf_load),
        .load_off  (ptr[PW-1:0]),
        .load_data (rx),
        .go        (commit_go),
        .go_base   (ptr[AW-1:PW]),
        .busy      (busy),
        .pending   (pending),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    twi_ee_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ptr),
        .rdata (rd_byte)
    );

    assign full_ptr  = {ext_q, rx};
    assign byte_end  = ev.fall && (bit_cnt == 4'd8) && (st != ST_IDLE);
    assign ack_end   = ev.fall && (bit_cnt == 4'd9) && (st != ST_IDLE);
    assign dev_ok    = dev_match(rx, strap_i, EXT) && !busy;
    assign buf_load  = byte_end && (st == ST_WDATA);
    assign commit_go = ev.stop && pending && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            rx      <= '0;
            tx      <= '1;
            ptr     <= '0;
            ext_q   <= '0;
            m_ack   <= 1'b0;
            pull    <= 1'b0;
        end else if (ev.start) begin
            st      <= ST_DEV;
            bit_cnt <= '0;
            pull    <= 1'b0;
        end else if (ev.stop) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            pull    <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (ev.rise) begin
                if (bit_cnt < 4'd8)  rx <= {rx[6:0], ev.sda};
                if (bit_cnt == 4'd8) m_ack <= ~ev.sda;
                if (bit_cnt != 4'd9) bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
                unique case (st)
                    ST_DEV: begin
                        if (dev_ok) begin
                            pull  <= 1'b1;
                            ext_q <= rx[EXTW:1];
                        end else begin
                            pull <= 1'b0;
                            st   <= ST_IDLE;
                        end
                    end
                    ST_PTR: begin
                        pull <= 1'b1;
                        ptr  <= full_ptr[AW-1:0];
                    end
                    ST_WDATA: begin
                        pull          <= 1'b1;
                        ptr[PW-1:0]   <= ptr[PW-1:0] + 1'b1;
                    end
                    default: pull <= 1'b0;
                endcase
            end else if (ack_end) begin
                pull    <= 1'b0;
                bit_cnt <= '0;
                if ((st == ST_DEV && rx[0]) || (st == ST_RDATA && m_ack)) begin
                    st   <= ST_RDATA;
                    tx   <= rd_byte[6:0];
                    pull <= ~rd_byte[7];
                    ptr  <= ptr + 1'b1;
                end else if (st == ST_DEV) begin
                    st <= ST_PTR;
                end else if (st == ST_PTR) begin
                    st <= ST_WDATA;
                end else if (st == ST_RDATA) begin
                    st <= ST_IDLE;
                end
            end else if (ev.fall && st == ST_RDATA && bit_cnt != 4'd0) begin
                pull <= ~tx[6];
                tx   <= {tx[5:0], 1'b1};
            end
        end
    end

    assign sda_pull_o = pull;

    AST_PULL_ON_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> $past(ev.fall)); // R3

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (byte_end && st == ST_DEV && busy) |=> !pull); // R7

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ev.stop)); // R8

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (byte_end && st == ST_RDATA) |=> !pull); // R11

endmodule

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_pull;
    logic sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    twi_eeprom_slave uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_pull_o (sda_pull)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // op (1 = read check), 9-bit address, data / expected byte
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 9'h005, 8'hA5},
        {1'b0, 9'h1F3, 8'h3C},
        {1'b0, 9'h0FF, 8'h81},
        {1'b1, 9'h005, 8'hA5},
        {1'b1, 9'h1F3, 8'h3C},
        {1'b1, 9'h0FF, 8'h81},
        {1'b1, 9'h1FF, 8'hFF},
        {1'b1, 9'h0F3, 8'hFF}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] devb(input logic [8:0] a, input logic rd);
        return {4'b1010, strap[2], strap[1], a[8], rd};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(x);
        acked = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack_it);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            d[i] = x;
        end
        bit_out(~ack_it);
    endtask

    task automatic write_run(input logic [8:0] a, input int n, input logic [7:0] first);
        logic k;
        bus_start();
        send_byte(devb(a, 1'b0), k);
        send_byte(a[7:0], k);
        for (int i = 0; i < n; i++) send_byte(first + 8'(i), k);
        bus_stop();
    endtask

    task automatic poll(output int tries);
        logic k;
        tries = 0;
        for (int i = 0; i < 40; i++) begin
            bus_start();
            send_byte(devb(9'h0, 1'b0), k);
            bus_stop();
            tries++;
            if (k) break;
        end
    endtask

    task automatic read_at(input logic [8:0] a, output logic [7:0] d);
        logic k;
        bus_start();
        send_byte(devb(a, 1'b0), k);
        send_byte(a[7:0], k);
        bus_start();
        send_byte(devb(a, 1'b1), k);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic [7:0] d;
        logic k;
        int tries;
        tick(5);
        rst = 1'b0;
        tick(5);

        // reset state
        chk("R12 pull off after reset", {7'b0, sda_pull}, 8'h00);
        read_at(9'h000, d);
        chk("R12 erased", d, 8'hFF);

        // vector table
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][17]) begin
                read_at(VEC[i][16:8], d);
                chk("R10 R2 random read", d, VEC[i][7:0]);
            end else begin
                write_run(VEC[i][16:8], 1, VEC[i][7:0]);
                poll(tries);
                chk("R4 write completes", {7'b0, tries < 40}, 8'h01);
            end
        end

        // R1: clocking without START
        scl = 1'b0; tick(Q);
        send_byte(devb(9'h0, 1'b0), k);
        chk("R1 no START no ack", {7'b0, k}, 8'h00);
        bus_stop();

        // R2: wrong code, strap mismatch, new strap
        bus_start(); send_byte(8'hB4, k); bus_stop();
        chk("R2 wrong code", {7'b0, k}, 8'h00);
        bus_start(); send_byte({4'b1010, 3'b010, 1'b0}, k); bus_stop();
        chk("R2 strap mismatch", {7'b0, k}, 8'h00);
        strap = 3'b011; tick(Q);
        bus_start(); send_byte({4'b1010, 3'b010, 1'b0}, k); bus_stop();
        chk("R2 new strap accepted", {7'b0, k}, 8'h01);
        strap = 3'b101; tick(Q);

        // R3: ack on every written byte
        bus_start();
        send_byte(devb(9'h020, 1'b0), k); chk("R3 ack select", {7'b0, k}, 8'h01);
        send_byte(8'h20, k);              chk("R3 ack pointer", {7'b0, k}, 8'h01);
        send_byte(8'h44, k);              chk("R3 ack data", {7'b0, k}, 8'h01);
        bus_stop();
        poll(tries);

        // R5: 18 bytes from offset 3 of page 0x40
        write_run(9'h043, 18, 8'h10);
        poll(tries);
        bus_start();
        send_byte(devb(9'h040, 1'b0), k);
        send_byte(8'h40, k);
        bus_start();
        send_byte(devb(9'h040, 1'b1), k);
        for (int off = 0; off < 16; off++) begin
            int idx;
            idx = (off - 3 + 16) % 16;
            if (idx + 16 <= 17) idx = idx + 16;
            recv_byte(d, off != 15);
            chk("R5 page wrap", d, 8'h10 + 8'(idx));
        end
        bus_stop();
        read_at(9'h050, d);
        chk("R5 next page untouched", d, 8'hFF);

        // R9: current read follows last byte read (0x51)
        bus_start();
        send_byte(devb(9'h0, 1'b1), k);
        recv_byte(d, 1'b0);
        bus_stop();
        chk("R9 current address read", d, 8'hFF);
        read_at(9'h044, d);
        bus_start();
        send_byte(devb(9'h0, 1'b1), k);
        recv_byte(d, 1'b0);
        bus_stop();
        chk("R9 current after 0x044", d, 8'h10 + 8'd2);

        // R6: partial page update
        write_run(9'h080, 16, 8'hC0);
        poll(tries);
        write_run(9'h085, 2, 8'h55);
        poll(tries);
        read_at(9'h084, d); chk("R6 below kept", d, 8'hC4);
        read_at(9'h085, d); chk("R6 written", d, 8'h55);
        read_at(9'h086, d); chk("R6 written", d, 8'h56);
        read_at(9'h087, d); chk("R6 above kept", d, 8'hC7);

        // R7: busy window
        write_run(9'h030, 1, 8'h5A);
        bus_start(); send_byte(devb(9'h0, 1'b0), k); bus_stop();
        chk("R7 busy no ack", {7'b0, k}, 8'h00);
        poll(tries);
        chk("R7 ack returns", {7'b0, tries < 40}, 8'h01);
        read_at(9'h030, d); chk("R7 data after busy", d, 8'h5A);

        // R8: no data -> no busy
        bus_start(); send_byte(devb(9'h031, 1'b0), k); send_byte(8'h31, k); bus_stop();
        bus_start(); send_byte(devb(9'h0, 1'b0), k); bus_stop();
        chk("R8 no write cycle", {7'b0, k}, 8'h01);

        // R11: sequential read wraps at end of memory
        write_run(9'h1FF, 1, 8'h77); poll(tries);
        write_run(9'h000, 1, 8'h99); poll(tries);
        bus_start();
        send_byte(devb(9'h1FE, 1'b0), k);
        send_byte(8'hFE, k);
        bus_start();
        send_byte(devb(9'h1FE, 1'b1), k);
        recv_byte(d, 1'b1); chk("R11 seq 0x1FE", d, 8'hFF);
        recv_byte(d, 1'b1); chk("R11 seq 0x1FF", d, 8'h77);
        recv_byte(d, 1'b1); chk("R11 seq wrap 0x000", d, 8'h99);
        recv_byte(d, 1'b0); chk("R11 seq 0x001", d, 8'hFF);
        chk("R11 released after NoACK", {7'b0, sda_pull}, 8'h00);
        bus_stop();

        // R13: STOP mid-byte keeps completed bytes only
        bus_start();
        send_byte(devb(9'h060, 1'b0), k);
        send_byte(8'h60, k);
        send_byte(8'h11, k);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        bus_stop();
        poll(tries);
        read_at(9'h060, d); chk("R13 complete byte kept", d, 8'h11);
        read_at(9'h061, d); chk("R13 partial byte dropped", d, 8'hFF);
        // repeated START discards pending data
        bus_start();
        send_byte(devb(9'h062, 1'b0), k);
        send_byte(8'h62, k);
        send_byte(8'h33, k);
        bus_start();
        send_byte(devb(9'h0, 1'b0), k);
        chk("R13 not busy after repeated START", {7'b0, k}, 8'h01);
        bus_stop();
        read_at(9'h062, d); chk("R13 discarded on START", d, 8'hFF);
        // START mid-byte returns to select phase
        bus_start();
        send_byte(devb(9'h063, 1'b0), k);
        send_byte(8'h63, k);
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        bus_start();
        send_byte(devb(9'h0, 1'b0), k);
        chk("R13 START mid-byte restarts", {7'b0, k}, 8'h01);
        bus_stop();
        read_at(9'h063, d); chk("R13 nothing written", d, 8'hFF);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule